// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath takes several clock cycles per instruction. It is a Moore machine with ten states, numbered 0 to 9, and it reads only the 6-bit opcode that the instruction register holds. In each state it drives every select and write enable of the datapath: the program-counter update, the memory access, the instruction-register load, the register-file write, both ALU operand selects, the ALU mode and the next-PC source.

Every instruction first passes through a fetch state (0) and a decode state (1). In the decode cycle the machine branches four ways on the opcode:

- Loads and stores share an address state (2). From there a load goes through a memory-read state (3) and a write-back state (4), and a store goes to a memory-write state (5).
- Register-to-register operations go through an execute state (6) and a write-back state (7).
- A branch-if-equal uses a compare state (8).
- A jump uses a single jump state (9).

As a result, branch and jump take three cycles, register operations and stores take four, and loads take five. The block is placed next to the datapath. Its outputs feed the datapath muxes and write enables directly, and its outputs depend only on the current state.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, the machine is in fetch. In fetch, mem_rd=1, instr_ld=1, pc_wr=1, alu_a_sel=0, alu_b_sel=01, alu_mode=00 and pc_next_sel=00. Each fetch lasts exactly one cycle.
- R2: Fetch is always followed by decode. In decode, alu_a_sel=0, alu_b_sel=11, alu_mode=00, and every write enable and mem_rd are 0.
- R3: In decode, opcode 0x23 (load) or 0x2B (store) leads to the address cycle. The address cycle drives alu_a_sel=1, alu_b_sel=10 and alu_mode=00.
- R4: After the address cycle, a load performs a memory read with mem_rd=1 and mem_addr_sel=1. It then performs a write-back with rf_wr=1, rf_dst_sel=0 and rf_data_sel=1. A load takes 5 cycles in total.
- R5: After the address cycle, a store drives mem_wr=1 and mem_addr_sel=1 for one cycle and then returns to fetch. A store takes 4 cycles in total.
- R6: Opcode 0x00 leads to an execute cycle with alu_a_sel=1, alu_b_sel=00 and alu_mode=10. This is followed by a write-back with rf_wr=1, rf_dst_sel=1 and rf_data_sel=0. The instruction takes 4 cycles in total.
- R7: Opcode 0x04 leads to a compare cycle with alu_a_sel=1, alu_b_sel=00, alu_mode=01, pc_wr_cond=1 and pc_next_sel=01. The instruction takes 3 cycles in total.
- R8: Opcode 0x02 leads to a jump cycle with pc_wr=1 and pc_next_sel=10. The instruction takes 3 cycles in total.
- R9: Any other opcode seen in decode returns the machine to fetch. Such an opcode produces no write of any kind and takes 2 cycles in total.
- R10: Every write enable and mem_rd are 0 in every state that does not list them as 1. Every select not listed for a state is driven to 0. At most one of pc_wr, pc_wr_cond, mem_wr and rf_wr is high in any cycle.
- R11: The opcode is consulted only in decode and in the address cycle. Its value in every other cycle has no effect on the sequence of outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OP_W | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU result is zero |
| mem_addr_sel | output | 1 | Memory address: 0 selects the PC, 1 selects the ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| instr_ld | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register: 0 selects the rt field, 1 selects the rd field |
| rf_data_sel | output | 1 | Write data: 0 selects the ALU result register, 1 selects the memory data register |
| alu_a_sel | output | 1 | ALU operand A: 0 selects the PC, 1 selects register A |
| alu_b_sel | output | 2 | ALU operand B: 00 selects register B, 01 selects the constant 4, 10 selects the immediate, 11 selects the immediate shifted left by 2 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 use the function field |
| pc_next_sel | output | 2 | Next PC: 00 selects the ALU, 01 selects the ALU result register, 10 selects the jump target |

## Verification
The bench builds two copies of the block side by side. One uses the default binary state register and the other uses STATE_ONEHOT=1, so both generate variants of the state storage face the same opcode stream and the same reference model. The opcode values keep their defaults, so the bench can count the cycles of every instruction class as well as those of unknown opcodes. Random opcodes are driven in every cycle in which the opcode must be ignored, which exercises R11 on every instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int NUM_STATES = 10;
   localparam int ST_W       = $clog2(NUM_STATES);

   typedef logic [ST_W-1:0] mcc_state_t;

   // State numbering is part of the behaviour: neighbours decode it.
   localparam mcc_state_t ST_FETCH  = 4'd0;
   localparam mcc_state_t ST_DECODE = 4'd1;
   localparam mcc_state_t ST_ADDR   = 4'd2;
   localparam mcc_state_t ST_MRD    = 4'd3;
   localparam mcc_state_t ST_LWB    = 4'd4;
   localparam mcc_state_t ST_MWR    = 4'd5;
   localparam mcc_state_t ST_EXEC   = 4'd6;
   localparam mcc_state_t ST_RWB    = 4'd7;
   localparam mcc_state_t ST_BEQ    = 4'd8;
   localparam mcc_state_t ST_JMP    = 4'd9;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       mem_addr_sel;
      logic       mem_rd;
      logic       mem_wr;
      logic       instr_ld;
      logic       rf_wr;
      logic       rf_dst_sel;
      logic       rf_data_sel;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic [1:0] alu_mode;
      logic [1:0] pc_next_sel;
   } mcc_ctrl_t;

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter int              OP_W         = 6,
   parameter logic [OP_W-1:0] OP_LOAD      = 6'h23,
   parameter logic [OP_W-1:0] OP_STORE     = 6'h2B,
   parameter logic [OP_W-1:0] OP_RTYPE     = 6'h00,
   parameter logic [OP_W-1:0] OP_BRANCH    = 6'h04,
   parameter logic [OP_W-1:0] OP_JUMP      = 6'h02,
   parameter bit              STATE_ONEHOT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   output mcc_state_t      state
);

   mcc_state_t nxt;

   always_comb begin
      nxt = ST_FETCH;
      case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
            else if (opcode == OP_RTYPE)                 nxt = ST_EXEC;
            else if (opcode == OP_BRANCH)                nxt = ST_BEQ;
            else if (opcode == OP_JUMP)                  nxt = ST_JMP;
            else                                         nxt = ST_FETCH;
         end
         ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_MRD : ST_MWR;
         ST_MRD:    nxt = ST_LWB;
         ST_EXEC:   nxt = ST_RWB;
         default:   nxt = ST_FETCH;
      endcase
   end

   generate
      if (STATE_ONEHOT) begin : g_onehot
         logic [NUM_STATES-1:0] hot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hot_q <= NUM_STATES'(1);
            else        hot_q <= NUM_STATES'(1) << nxt;
         end

         always_comb begin
            state = '0;
            for (int i = 0; i < NUM_STATES; i++)
               if (hot_q[i]) state = state | ST_W'(i);
         end

         assert_hot_integrity_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hot_q) == 1);
      end else begin : g_binary
         mcc_state_t st_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ST_FETCH;
            else        st_q <= nxt;
         end

         assign state = st_q;

         assert_state_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
            int'(st_q) < NUM_STATES);
      end
   endgenerate

   assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
   import mcc_pkg::*;
(
   input  mcc_state_t state,
   output mcc_ctrl_t  ctrl
);

   always_comb begin
      ctrl = '0;
      case (state)
         ST_FETCH: begin
            ctrl.mem_rd    = 1'b1;
            ctrl.instr_ld  = 1'b1;
            ctrl.pc_wr     = 1'b1;
            ctrl.alu_b_sel = 2'b01;
         end
         ST_DECODE: ctrl.alu_b_sel = 2'b11;
         ST_ADDR: begin
            ctrl.alu_a_sel = 1'b1;
            ctrl.alu_b_sel = 2'b10;
         end
         ST_MRD: begin
            ctrl.mem_rd       = 1'b1;
            ctrl.mem_addr_sel = 1'b1;
         end
         ST_LWB: begin
            ctrl.rf_wr       = 1'b1;
            ctrl.rf_data_sel = 1'b1;
         end
         ST_MWR: begin
            ctrl.mem_wr       = 1'b1;
            ctrl.mem_addr_sel = 1'b1;
         end
         ST_EXEC: begin
            ctrl.alu_a_sel = 1'b1;
            ctrl.alu_mode  = 2'b10;
         end
         ST_RWB: begin
            ctrl.rf_wr      = 1'b1;
            ctrl.rf_dst_sel = 1'b1;
         end
         ST_BEQ: begin
            ctrl.alu_a_sel   = 1'b1;
            ctrl.alu_mode    = 2'b01;
            ctrl.pc_wr_cond  = 1'b1;
            ctrl.pc_next_sel = 2'b01;
         end
         ST_JMP: begin
            ctrl.pc_wr       = 1'b1;
            ctrl.pc_next_sel = 2'b10;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
   import mcc_pkg::*;
#(
   parameter int              OP_W         = 6,
   parameter logic [OP_W-1:0] OP_LOAD      = 6'h23,
   parameter logic [OP_W-1:0] OP_STORE     = 6'h2B,
   parameter logic [OP_W-1:0] OP_RTYPE     = 6'h00,
   parameter logic [OP_W-1:0] OP_BRANCH    = 6'h04,
   parameter logic [OP_W-1:0] OP_JUMP      = 6'h02,
   parameter bit              STATE_ONEHOT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   output logic            pc_wr,
   output logic            pc_wr_cond,
   output logic            mem_addr_sel,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            instr_ld,
   output logic            rf_wr,
   output logic            rf_dst_sel,
   output logic            rf_data_sel,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic [1:0]      alu_mode,
   output logic [1:0]      pc_next_sel
);

   localparam int N_OPS = 5;
   localparam logic [N_OPS*OP_W-1:0] OP_SET = {OP_LOAD, OP_STORE, OP_RTYPE, OP_BRANCH, OP_JUMP};

   generate
      if (OP_W < 1) begin : g_bad_width
         $error("mcc_ctrl_fsm: OP_W must be at least 1");
      end
      for (genvar a = 0; a < N_OPS; a++) begin : g_chk_a
         for (genvar b = a + 1; b < N_OPS; b++) begin : g_chk_b
            if (OP_SET[a*OP_W +: OP_W] == OP_SET[b*OP_W +: OP_W]) begin : g_dup
               $error("mcc_ctrl_fsm: opcode parameters must be distinct");
            end
         end
      end
   endgenerate

   mcc_state_t state;
   mcc_ctrl_t  ctrl;

   mcc_seq #(
      .OP_W        (OP_W),
      .OP_LOAD     (OP_LOAD),
      .OP_STORE    (OP_STORE),
      .OP_RTYPE    (OP_RTYPE),
      .OP_BRANCH   (OP_BRANCH),
      .OP_JUMP     (OP_JUMP),
      .STATE_ONEHOT(STATE_ONEHOT)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .opcode(opcode),
      .state (state)
   );

   mcc_decode u_decode (
      .state(state),
      .ctrl (ctrl)
   );

   assign pc_wr        = ctrl.pc_wr;
   assign pc_wr_cond   = ctrl.pc_wr_cond;
   assign mem_addr_sel = ctrl.mem_addr_sel;
   assign mem_rd       = ctrl.mem_rd;
   assign mem_wr       = ctrl.mem_wr;
   assign instr_ld     = ctrl.instr_ld;
   assign rf_wr        = ctrl.rf_wr;
   assign rf_dst_sel   = ctrl.rf_dst_sel;
   assign rf_data_sel  = ctrl.rf_data_sel;
   assign alu_a_sel    = ctrl.alu_a_sel;
   assign alu_b_sel    = ctrl.alu_b_sel;
   assign alu_mode     = ctrl.alu_mode;
   assign pc_next_sel  = ctrl.pc_next_sel;

   logic known_op;
   assign known_op = (opcode == OP_LOAD) || (opcode == OP_STORE) || (opcode == OP_RTYPE) ||
                     (opcode == OP_BRANCH) || (opcode == OP_JUMP);

   assert_fetch_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      instr_ld |=> !instr_ld);

   assert_lw_wb_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_data_sel) |=> instr_ld);

   assert_store_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> instr_ld);

   assert_rtype_wb_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_dst_sel) |=> instr_ld);

   assert_branch_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_cond |=> instr_ld);

   assert_bad_op_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && !known_op) |=> (state == ST_FETCH));

   assert_single_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_wr, pc_wr_cond, mem_wr, rf_wr}));

endmodule

// File: tb/mcc_ctrl_fsm_bench.sv
module mcc_ctrl_fsm_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;

   always #2 clk = ~clk;

   logic        a_pcw, a_pcc, a_mas, a_mrd, a_mwr, a_ild, a_rfw, a_rds, a_rdt, a_aas;
   logic [1:0]  a_abs, a_amd, a_pns;
   logic        b_pcw, b_pcc, b_mas, b_mrd, b_mwr, b_ild, b_rfw, b_rds, b_rdt, b_aas;
   logic [1:0]  b_abs, b_amd, b_pns;

   mcc_ctrl_fsm u_mcc_ctrl_fsm (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .pc_wr(a_pcw), .pc_wr_cond(a_pcc), .mem_addr_sel(a_mas), .mem_rd(a_mrd),
      .mem_wr(a_mwr), .instr_ld(a_ild), .rf_wr(a_rfw), .rf_dst_sel(a_rds),
      .rf_data_sel(a_rdt), .alu_a_sel(a_aas), .alu_b_sel(a_abs), .alu_mode(a_amd),
      .pc_next_sel(a_pns)
   );

   mcc_ctrl_fsm #(.STATE_ONEHOT(1'b1)) u_mcc_ctrl_fsm_oh (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .pc_wr(b_pcw), .pc_wr_cond(b_pcc), .mem_addr_sel(b_mas), .mem_rd(b_mrd),
      .mem_wr(b_mwr), .instr_ld(b_ild), .rf_wr(b_rfw), .rf_dst_sel(b_rds),
      .rf_data_sel(b_rdt), .alu_a_sel(b_aas), .alu_b_sel(b_abs), .alu_mode(b_amd),
      .pc_next_sel(b_pns)
   );

   wire [15:0] vec_a = {a_pcw, a_pcc, a_mas, a_mrd, a_mwr, a_ild, a_rfw, a_rds, a_rdt,
                        a_aas, a_abs, a_amd, a_pns};
   wire [15:0] vec_b = {b_pcw, b_pcc, b_mas, b_mrd, b_mwr, b_ild, b_rfw, b_rds, b_rdt,
                        b_aas, b_abs, b_amd, b_pns};

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model: instruction phase number, advanced on every clock.
   int mstate = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mstate <= 0;
      else begin
         case (mstate)
            0: mstate <= 1;
            1: mstate <= (opcode == 6'h23 || opcode == 6'h2B) ? 2 :
                         (opcode == 6'h00) ? 6 : (opcode == 6'h04) ? 8 :
                         (opcode == 6'h02) ? 9 : 0;
            2: mstate <= (opcode == 6'h23) ? 3 : 5;
            3: mstate <= 4;
            6: mstate <= 7;
            default: mstate <= 0;
         endcase
      end
   end

   // Order: pcw pcc mas mrd mwr ild rfw rds rdt aas abs[2] amd[2] pns[2]
   function automatic logic [15:0] exp_vec(int s);
      case (s)
         0: return 16'b1_0_0_1_0_1_0_0_0_0_01_00_00;
         1: return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00;
         2: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00;
         3: return 16'b0_0_1_1_0_0_0_0_0_0_00_00_00;
         4: return 16'b0_0_0_0_0_0_1_0_1_0_00_00_00;
         5: return 16'b0_0_1_0_1_0_0_0_0_0_00_00_00;
         6: return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00;
         7: return 16'b0_0_0_0_0_0_1_1_0_0_00_00_00;
         8: return 16'b0_1_0_0_0_0_0_0_0_1_00_01_01;
         9: return 16'b1_0_0_0_0_0_0_0_0_0_00_00_10;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string tag_of(int s);
      case (s)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3, 4: return "R4";
         5: return "R5";
         6, 7: return "R6";
         8: return "R7";
         9: return "R8";
         default: return "R10";
      endcase
   endfunction

   function automatic int exp_cycles(logic [5:0] op);
      case (op)
         6'h23: return 5;
         6'h2B: return 4;
         6'h00: return 4;
         6'h04: return 3;
         6'h02: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic string cyc_tag(logic [5:0] op);
      case (op)
         6'h23: return "R4/R11";
         6'h2B: return "R5/R11";
         6'h00: return "R6/R11";
         6'h04: return "R7/R11";
         6'h02: return "R8/R11";
         default: return "R9/R11";
      endcase
   endfunction

   logic [5:0] ops[$] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h3F, 6'h23, 6'h23,
                          6'h05, 6'h02, 6'h00, 6'h00, 6'h2B, 6'h04, 6'h2A, 6'h01,
                          6'h23, 6'h02, 6'h04, 6'h2B, 6'h00, 6'h24, 6'h23, 6'h04};
   logic [5:0] cur_op = 6'h00;
   logic [5:0] meas_op = 6'h00;
   int cyc_cnt = 0;

   always @(negedge clk) begin
      if (!done) begin
         // Per-cycle compare of both variants against the model (R10 covers unlisted bits).
         checks++;
         if (vec_a !== exp_vec(mstate)) begin
            errors++;
            $display("FAIL %s/R10 binary state %0d: got %b expected %b",
                     tag_of(mstate), mstate, vec_a, exp_vec(mstate));
         end
         checks++;
         if (vec_b !== exp_vec(mstate)) begin
            errors++;
            $display("FAIL %s/R10 onehot state %0d: got %b expected %b",
                     tag_of(mstate), mstate, vec_b, exp_vec(mstate));
         end
         if (rst_n) begin
            // Cycle count per instruction, measured on the fetch strobe.
            if (a_ild) begin
               if (cyc_cnt > 0) begin
                  checks++;
                  if (cyc_cnt != exp_cycles(meas_op)) begin
                     errors++;
                     $display("FAIL %s opcode %h cycles: got %0d expected %0d",
                              cyc_tag(meas_op), meas_op, cyc_cnt, exp_cycles(meas_op));
                  end
               end
               cyc_cnt = 1;
            end else begin
               cyc_cnt++;
            end
            // Opcode drive: real value only where it is consulted (R11), noise elsewhere.
            if (mstate == 0) begin
               if (ops.size() == 0) done = 1'b1;
               else begin
                  cur_op  = ops.pop_front();
                  meas_op = cur_op;
               end
               opcode = 6'($urandom);
            end else if (mstate == 1 || mstate == 2) begin
               opcode = cur_op;
            end else begin
               opcode = 6'($urandom);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      wait (done);
      @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule